// File: doc/BRIEF.md
# Edge-Selectable Event Divider Counter

This block counts transitions of an asynchronous event signal in the system clock domain and divides them by a programmable ratio. The event signal passes through a two-stage synchronizer, and a third register keeps the previous settled level. The direction of transition that counts is picked by an 8-bit select code. Each counted transition either advances an 8-bit count or, if the count already equals the compare value, returns the count to 00H and raises a one-cycle interrupt pulse.

The result is a periodic event divider: with compare value N, the interrupt fires once every N+1 counted transitions. Software sets the select code and the compare value, then sets the enable bit. Clearing the enable bit stops the count and holds it at 00H.

Top module: `evcnt_div`

## Requirements
- R1: After reset, `count_q` is 00H and `irq` is 0.
- R2: With `edge_sel` = 01H and `run_en` = 1, each low-to-high transition of `evt_in` counts, and high-to-low transitions leave `count_q` unchanged.
- R3: With `edge_sel` = 00H and `run_en` = 1, each high-to-low transition of `evt_in` counts, and low-to-high transitions leave `count_q` unchanged.
- R4: With any `edge_sel` value other than 00H or 01H, no transition counts, and `count_q` holds its value.
- R5: While `run_en` is 0, `count_q` reads 00H from the clock edge after the bit is sampled low. Transitions arriving in that time are ignored, and `irq` stays 0.
- R6: A counted transition that arrives while `count_q` equals `cmp_val` sets `count_q` to 00H instead of incrementing it. The same transition drives `irq` high for exactly one clock, in the same cycle in which `count_q` shows 00H. One interrupt period is therefore `cmp_val`+1 counted transitions.
- R7: With `cmp_val` = 00H, every counted transition raises `irq`, and `count_q` stays at 00H.
- R8: With `cmp_val` = FFH, the count runs through every value 01H..FFH, and the 256th counted transition returns it to 00H with an `irq` pulse.
- R9: A change of `edge_sel` while `evt_in` is steady is never counted. The new code applies from the next transition.
- R10: A transition of `evt_in` that counts changes `count_q` three clock edges after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 1 | Asynchronous event signal |
| run_en | input | 1 | Count enable; 0 stops the count and clears it |
| edge_sel | input | 8 | Edge select code: 00H counts falling transitions, 01H counts rising transitions |
| cmp_val | input | 8 | Compare value, 00H..FFH |
| count_q | output | 8 | Current count |
| irq | output | 1 | One-clock interrupt pulse on a compare match |

## Verification
Changing the edge select while the event level is held steady must produce no count. The stimulus does this with the event held high under the rising code and then switches to the falling code. It checks that the count stays put, and then that the next falling transition is counted. The full-range case needs 256 rising transitions with the compare value at FFH, and each one is checked as it arrives. The stimulus also drops the enable in the middle of a count and toggles the event input while disabled, to show that the count is cleared and that none of those transitions are counted.

// File: rtl/evcnt_div.sv
module evcnt_div #(
  parameter int W = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_in,
  input  logic         run_en,
  input  logic [7:0]   edge_sel,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] count_q,
  output logic         irq
);
  localparam logic [7:0] SEL_FALL = 8'h00;
  localparam logic [7:0] SEL_RISE = 8'h01;

  logic [SYNC-1:0] sync_q;
  logic            last_q;
  logic            lvl;
  logic            rise, fall, strike, hit;

  assign lvl = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], evt_in};
      last_q <= lvl;
    end

  assign rise   = lvl & ~last_q;
  assign fall   = ~lvl & last_q;
  assign strike = run_en & (((edge_sel == SEL_RISE) & rise) |
                            ((edge_sel == SEL_FALL) & fall));
  assign hit    = strike & (count_q == cmp_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= hit;
      if (!run_en)     count_q <= '0;
      else if (hit)    count_q <= '0;
      else if (strike) count_q <= count_q + 1'b1;
    end

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count_q == '0));

  // R5
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count_q == '0) && !irq);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |->
      ((count_q == W'($past(count_q) + 1'b1)) || (count_q == '0)));

  // R10
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) && $past(run_en) |-> ($past(lvl) != $past(last_q)));
endmodule

// File: tb/tb_evcnt_div.sv
`timescale 1ns/1ps
module tb_evcnt_div;
  logic clk = 0, rst_n = 0, evt_in = 0, run_en = 0;
  logic [7:0] edge_sel = 8'h01, cmp_val = 8'h00;
  logic [7:0] count_q;
  logic irq;

  evcnt_div dut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .run_en(run_en),
                 .edge_sel(edge_sel), .cmp_val(cmp_val), .count_q(count_q), .irq(irq));

  always #2 clk = ~clk;

  typedef struct { int due; logic [7:0] c; logic i; string tag; } item_t;
  item_t q[$];
  int cyc = 0, total = 0, bad = 0;
  logic [7:0] mcnt = 0;
  logic mlvl = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (count_q !== it.c || irq !== it.i) begin
        bad++;
        $display("FAIL %s: count=%0h irq=%0b expected count=%0h irq=%0b",
                 it.tag, count_q, irq, it.c, it.i);
      end
    end

  task automatic push(int dly, logic [7:0] c, logic i, string tag);
    item_t it;
    it.due = cyc + dly; it.c = c; it.i = i; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(logic lvl, string tag);
    logic valid, hit;
    @(negedge clk);
    valid = run_en && (lvl != mlvl) &&
            ((edge_sel == 8'h01 && lvl) || (edge_sel == 8'h00 && !lvl));
    evt_in = lvl;
    mlvl = lvl;
    push(2, mcnt, 1'b0, "R10");
    hit = valid && (mcnt == cmp_val);
    if (hit) mcnt = 0;
    else if (valid) mcnt = mcnt + 1;
    push(3, mcnt, hit, hit ? "R6" : tag);
    push(4, mcnt, 1'b0, "R6");
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(string tag);
    step(1'b1, tag);
    step(1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    push(1, 8'h00, 1'b0, "R1");
    repeat (2) @(negedge clk);
    run_en = 1; edge_sel = 8'h01; cmp_val = 8'h03;
    for (int k = 0; k < 8; k++) pulse("R2");
    edge_sel = 8'h00; cmp_val = 8'h02;
    for (int k = 0; k < 5; k++) pulse("R3");
    edge_sel = 8'h02;
    for (int k = 0; k < 3; k++) pulse("R4");
    edge_sel = 8'h01;
    step(1'b1, "R2");
    @(negedge clk); run_en = 0; mcnt = 0;
    push(1, 8'h00, 1'b0, "R5");
    step(1'b0, "R5"); step(1'b1, "R5"); step(1'b0, "R5");
    @(negedge clk); run_en = 1;
    edge_sel = 8'h01; cmp_val = 8'h05;
    pulse("R2"); step(1'b1, "R2");
    @(negedge clk); edge_sel = 8'h00;
    push(3, mcnt, 1'b0, "R9");
    repeat (5) @(negedge clk);
    step(1'b0, "R9");
    step(1'b1, "R9");
    @(negedge clk); edge_sel = 8'h01;
    push(3, mcnt, 1'b0, "R9");
    repeat (5) @(negedge clk);
    step(1'b0, "R9");
    cmp_val = 8'h00;
    @(negedge clk); run_en = 0; mcnt = 0;
    @(negedge clk); run_en = 1;
    for (int k = 0; k < 4; k++) pulse("R7");
    cmp_val = 8'hFF;
    @(negedge clk); run_en = 0; mcnt = 0;
    @(negedge clk); run_en = 1;
    for (int k = 0; k < 257; k++) pulse("R8");
    repeat (6) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule